// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block gathers the state of a UART's receive and transmit FIFOs into interrupt status. It takes the FIFO occupancy counts and the single-cycle event pulses for receive overflow and receive timeout. From these it derives a live status word that is recomputed combinationally on every cycle. Selected live conditions and the event pulses are accumulated into a sticky status word. That word keeps each bit until software clears it by writing one to it.

A separate mask selects which sticky bits drive the single level interrupt line. Software changes the mask only through two write addresses. One address sets the bits written as one, and the other clears them. The receive and transmit trigger levels are ordinary registers on the same port. Reads are combinational from a separate read address.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Live status bit 2 (receive full) is high exactly when the receive count equals DEPTH. Live bit 1 (receive empty) is high exactly when the receive count is zero.
- R2: Live bit 0 (receive trigger) is high when the receive count is greater than or equal to the receive trigger level.
- R3: Live bit 4 (transmit full) is high when the transmit count equals DEPTH. Live bit 3 (transmit empty) is high when the transmit count is zero.
- R4: Live bit 5 (transmit trigger) is high when the transmit count is at least the transmit trigger level. While it is high, each clock edge sets sticky bit 7. It never sets sticky bit 5.
- R5: On each clock edge, live bits 0 to 4 are ORed into sticky bits 0 to 4. They stay set after the live condition goes away.
- R6: A receive-overflow pulse sets sticky bit 5 at the next clock edge. A timeout pulse sets sticky bit 6 at the next clock edge.
- R7: A write to address 0 ORs the low 8 data bits into the mask. A write to address 1 clears the mask bits written as one. Address 2 reads the mask.
- R8: A write to address 3 clears each sticky bit written as one. Bits written as zero are unchanged. Address 3 reads the sticky word and address 4 reads the live word.
- R9: When a sticky bit is cleared in the same cycle as its set condition, the bit ends up set.
- R10: The irq output is high exactly when the bitwise AND of the mask and the sticky word is nonzero.
- R11: While rst_n is low at a clock edge, the mask and the sticky word become zero and both trigger levels become 32.
- R12: A write to address 5 sets the receive trigger level and a write to address 6 sets the transmit trigger level, from the low CNT_W data bits. Both addresses read back the stored level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_ovr_evt | input | 1 | Receive overflow pulse |
| timeout_evt | input | 1 | Receive timeout pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- An active empty or transmit-trigger condition shows up in the sticky word one edge later.
- Sticky bits never fall without a clear write.
- The event pulses reach their sticky bits.
- Mask writes take effect.
- The interrupt stays low when no masked bit is set.
- Receive full and receive empty are never high together.

Only the bench scenarios can show the following:
- The exact threshold boundaries of the trigger comparisons at full depth and at reprogrammed levels.
- Selective write-one-to-clear.
- The set-over-clear priority on a bit whose condition is still live.
- The reset values of the trigger levels, seen through the read port.

// File: rtl/uart_irq_pkg.sv
// Package: bit positions and register addresses shared by the
// interrupt status controller, its submodules and its checker.
package uart_irq_pkg;
    localparam int IRQ_W  = 8;   // sticky word and mask width
    localparam int LIVE_W = 6;   // live status width

    // live status bit positions
    localparam int ST_RX_TRIG  = 0;
    localparam int ST_RX_EMPTY = 1;
    localparam int ST_RX_FULL  = 2;
    localparam int ST_TX_EMPTY = 3;
    localparam int ST_TX_FULL  = 4;
    localparam int ST_TX_TRIG  = 5;

    // sticky-only bit positions
    localparam int IS_RX_OVR  = 5;
    localparam int IS_TIMEOUT = 6;
    localparam int IS_TX_TRIG = 7;

    // live bits folded straight into the same sticky position
    localparam logic [LIVE_W-1:0] FOLD_MASK = 6'b01_1111;

    localparam int ADDR_W = 3;
    typedef enum logic [ADDR_W-1:0] {
        A_MASK_SET = 3'd0,
        A_MASK_CLR = 3'd1,
        A_MASK     = 3'd2,
        A_STICKY   = 3'd3,
        A_LIVE     = 3'd4,
        A_RX_TRIG  = 3'd5,
        A_TX_TRIG  = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/uart_irq_live.sv
// Live status decode. Purely combinational, so the word is recomputed
// from the counts and trigger levels on every cycle.
// Assumes DEPTH fits in CNT_W bits.
module uart_irq_live
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_trig,
    input  logic [CNT_W-1:0]  tx_trig,
    output logic [LIVE_W-1:0] live
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt  [2];
    logic [CNT_W-1:0] lvl  [2];
    logic [1:0]       full_d, empty_d, trig_d;

    assign cnt[0] = rx_count;
    assign cnt[1] = tx_count;
    assign lvl[0] = rx_trig;
    assign lvl[1] = tx_trig;

    // Same threshold decode for the receive (0) and transmit (1) side.
    for (genvar d = 0; d < 2; d++) begin : g_dir
        assign full_d[d]  = (cnt[d] == FULL_CNT);
        assign empty_d[d] = (cnt[d] == '0);
        assign trig_d[d]  = (cnt[d] >= lvl[d]);
    end

    // Pack the decoded conditions into the live status layout.
    always_comb begin
        live              = '0;
        live[ST_RX_TRIG]  = trig_d[0];
        live[ST_RX_EMPTY] = empty_d[0];
        live[ST_RX_FULL]  = full_d[0];
        live[ST_TX_EMPTY] = empty_d[1];
        live[ST_TX_FULL]  = full_d[1];
        live[ST_TX_TRIG]  = trig_d[1];
    end
endmodule

// File: rtl/uart_irq_cfg.sv
// Configuration registers: interrupt mask (set and clear ports only)
// and the two trigger levels.
// Assumes DATA_W >= IRQ_W and DATA_W >= CNT_W.
module uart_irq_cfg
    import uart_irq_pkg::*;
#(
    parameter int CNT_W    = 7,
    parameter int DATA_W   = 8,
    parameter int TRIG_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [IRQ_W-1:0]  mask,
    output logic [CNT_W-1:0]  rx_trig,
    output logic [CNT_W-1:0]  tx_trig
);
    logic [IRQ_W-1:0] wbits;
    assign wbits = wr_data[IRQ_W-1:0];

    // Mask update: set port ORs bits in, clear port removes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr_en && wr_addr == A_MASK_SET) begin
            mask <= mask | wbits;
        end else if (wr_en && wr_addr == A_MASK_CLR) begin
            mask <= mask & ~wbits;
        end
    end

    // Trigger level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_trig <= CNT_W'(TRIG_RST);
            tx_trig <= CNT_W'(TRIG_RST);
        end else if (wr_en && wr_addr == A_RX_TRIG) begin
            rx_trig <= wr_data[CNT_W-1:0];
        end else if (wr_en && wr_addr == A_TX_TRIG) begin
            tx_trig <= wr_data[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/uart_irq_sticky.sv
// Sticky interrupt status. It accumulates folded live bits, the
// transmit-trigger bit and the event pulses, and is cleared by writing
// one. When a bit is set and cleared in the same cycle, the set wins.
module uart_irq_sticky
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LIVE_W-1:0] live,
    input  logic              rx_ovr_evt,
    input  logic              timeout_evt,
    input  logic [IRQ_W-1:0]  clr_bits,
    output logic [IRQ_W-1:0]  sticky
);
    logic [IRQ_W-1:0] set_bits;

    // Gather every source of a sticky set for this cycle.
    always_comb begin
        set_bits             = IRQ_W'(live & FOLD_MASK);
        set_bits[IS_RX_OVR]  = rx_ovr_evt;
        set_bits[IS_TIMEOUT] = timeout_evt;
        set_bits[IS_TX_TRIG] = live[ST_TX_TRIG];
    end

    // Clear first, then set, so a set in the same cycle takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky <= '0;
        else        sticky <= (sticky & ~clr_bits) | set_bits;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
// Top level: connects the live decode, the configuration registers and
// the sticky status, and provides the read mux and the level interrupt.
// Reads are combinational. Writes take effect at the next clock edge.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int CNT_W    = $clog2(DEPTH) + 1,
    parameter int DATA_W   = 8,
    parameter int TRIG_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              rx_ovr_evt,
    input  logic              timeout_evt,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [LIVE_W-1:0] live_st;
    logic [IRQ_W-1:0]  mask_q, sticky_q, clr_bits;
    logic [CNT_W-1:0]  rx_trig_q, tx_trig_q;

    uart_irq_live #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_live (
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_trig  (rx_trig_q),
        .tx_trig  (tx_trig_q),
        .live     (live_st)
    );

    uart_irq_cfg #(.CNT_W(CNT_W), .DATA_W(DATA_W), .TRIG_RST(TRIG_RST)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mask     (mask_q),
        .rx_trig  (rx_trig_q),
        .tx_trig  (tx_trig_q)
    );

    // Write-one-to-clear strobe for the sticky word.
    assign clr_bits = (wr_en && wr_addr == A_STICKY) ? wr_data[IRQ_W-1:0] : '0;

    uart_irq_sticky u_sticky (
        .clk         (clk),
        .rst_n       (rst_n),
        .live        (live_st),
        .rx_ovr_evt  (rx_ovr_evt),
        .timeout_evt (timeout_evt),
        .clr_bits    (clr_bits),
        .sticky      (sticky_q)
    );

    // Combinational read mux. The set and clear ports read as zero.
    always_comb begin
        case (rd_addr)
            A_MASK:    rd_data = DATA_W'(mask_q);
            A_STICKY:  rd_data = DATA_W'(sticky_q);
            A_LIVE:    rd_data = DATA_W'(live_st);
            A_RX_TRIG: rd_data = DATA_W'(rx_trig_q);
            A_TX_TRIG: rd_data = DATA_W'(tx_trig_q);
            default:   rd_data = '0;
        endcase
    end

    // Level interrupt from masked sticky bits.
    assign irq = |(mask_q & sticky_q);
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Checker for uart_irq_ctrl, attached with bind. It observes the ports
// and the mask, sticky and live signals that the submodules drive.
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rx_ovr_evt,
    input logic              timeout_evt,
    input logic              irq,
    input logic [IRQ_W-1:0]  mask,
    input logic [IRQ_W-1:0]  sticky,
    input logic [LIVE_W-1:0] live
);
    p_rx_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(live[ST_RX_FULL] && live[ST_RX_EMPTY]));

    p_tx_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        live[ST_TX_TRIG] |=> sticky[IS_TX_TRIG]);

    p_sticky_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_STICKY) |=> ((sticky & $past(sticky)) == $past(sticky)));

    p_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr_evt |=> sticky[IS_RX_OVR]);

    p_tmo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |=> sticky[IS_TIMEOUT]);

    p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MASK_SET) |=>
        ((mask & $past(wr_data[IRQ_W-1:0])) == $past(wr_data[IRQ_W-1:0])));

    p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MASK_CLR) |=> ((mask & $past(wr_data[IRQ_W-1:0])) == '0));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        live[ST_RX_EMPTY] |=> sticky[ST_RX_EMPTY]);

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & sticky) == '0) |-> !irq);

    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (sticky == '0 && mask == '0));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rx_ovr_evt  (rx_ovr_evt),
    .timeout_evt (timeout_evt),
    .irq         (irq),
    .mask        (mask_q),
    .sticky      (sticky_q),
    .live        (live_st)
);

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
// Bench for uart_irq_ctrl. A behavioural model updated on each rising
// edge is compared with irq on every falling edge. Directed checks read
// registers through the read port.
module uart_irq_ctrl_test;
    localparam int DEPTH = 64;
    localparam int CNT_W = 7;
    localparam int DW    = 8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [CNT_W-1:0] rx_count = 0, tx_count = 0;
    logic          rx_ovr_evt = 0, timeout_evt = 0;
    logic          wr_en = 0;
    logic [2:0]    wr_addr = 0, rd_addr = 0;
    logic [DW-1:0] wr_data = 0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int checks = 0, errors = 0;
    bit done = 0, started = 0;

    // model state
    int m_mask = 0, m_sticky = 0, m_rxt = 32, m_txt = 32;

    uart_irq_ctrl #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .rx_ovr_evt(rx_ovr_evt), .timeout_evt(timeout_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic int live_of(int rxc, int txc, int rxt, int txt);
        int v = 0;
        if (rxc >= rxt)   v |= 1;
        if (rxc == 0)     v |= 2;
        if (rxc == DEPTH) v |= 4;
        if (txc == 0)     v |= 8;
        if (txc == DEPTH) v |= 16;
        if (txc >= txt)   v |= 32;
        return v;
    endfunction

    function automatic int exp_rd(int a);
        case (a)
            2: return m_mask;
            3: return m_sticky;
            4: return live_of(int'(rx_count), int'(tx_count), m_rxt, m_txt);
            5: return m_rxt;
            6: return m_txt;
            default: return 0;
        endcase
    endfunction

    // Reference model step at every rising edge.
    always @(posedge clk) begin
        int lv, setb, clr;
        if (!rst_n) begin
            m_mask = 0; m_sticky = 0; m_rxt = 32; m_txt = 32; started = 1;
        end else begin
            lv   = live_of(int'(rx_count), int'(tx_count), m_rxt, m_txt);
            setb = (lv & 31) | (rx_ovr_evt ? 32 : 0) | (timeout_evt ? 64 : 0)
                 | (((lv >> 5) & 1) != 0 ? 128 : 0);
            clr  = (wr_en && wr_addr == 3) ? int'(wr_data) : 0;
            m_sticky = ((m_sticky & ~clr) | setb) & 255;
            if (wr_en) begin
                case (int'(wr_addr))
                    0: m_mask = m_mask | int'(wr_data);
                    1: m_mask = m_mask & ~int'(wr_data) & 255;
                    5: m_rxt  = int'(wr_data) & 127;
                    6: m_txt  = int'(wr_data) & 127;
                    default: ;
                endcase
            end
        end
    end

    // irq compared against the model on every falling edge (R10).
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            checks++;
            if (irq !== ((m_mask & m_sticky) != 0)) begin
                errors++;
                $display("FAIL R10 irq actual=%0b expected=%0b", irq, (m_mask & m_sticky) != 0);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic wr(int a, int d);
        wr_en = 1; wr_addr = 3'(a); wr_data = DW'(d);
        tick();
        wr_en = 0;
    endtask

    // Read a register and compare it with the model.
    task automatic chk_rd(string tag, int a);
        int e;
        rd_addr = 3'(a); #1;
        e = exp_rd(a);
        checks++;
        if (int'(rd_data) != e) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%0h expected=%0h", tag, a, rd_data, e);
        end
    endtask

    // Compare one register bit with a literal expected value.
    task automatic chk_bit(string tag, int a, int b, bit e);
        rd_addr = 3'(a); #1;
        checks++;
        if (rd_data[b] !== e) begin
            errors++;
            $display("FAIL %s addr=%0d bit=%0d actual=%0b expected=%0b", tag, a, b, rd_data[b], e);
        end
    endtask

    task automatic chk_val(string tag, int a, int e);
        rd_addr = 3'(a); #1;
        checks++;
        if (int'(rd_data) != e) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%0h expected=%0h", tag, a, rd_data, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        // R11 reset values
        chk_val("R11", 2, 0);
        chk_val("R11", 3, 0);
        chk_val("R11", 5, 32);
        chk_val("R11", 6, 32);
        rst_n = 1;
        tick();
        // R1 full and empty
        rx_count = 64; #1;
        chk_bit("R1", 4, 2, 1);
        chk_bit("R1", 4, 1, 0);
        tick();
        rx_count = 0; #1;
        chk_bit("R1", 4, 1, 1);
        chk_bit("R1", 4, 2, 0);
        // R2 trigger boundary
        rx_count = 31; #1; chk_bit("R2", 4, 0, 0);
        rx_count = 32; #1; chk_bit("R2", 4, 0, 1);
        // R3 transmit full and empty
        tx_count = 64; #1;
        chk_bit("R3", 4, 4, 1);
        chk_bit("R3", 4, 3, 0);
        tx_count = 0; #1;  chk_bit("R3", 4, 3, 1);
        // R4 transmit trigger to sticky bit 7, not bit 5
        tx_count = 40; #1; chk_bit("R4", 4, 5, 1);
        tick();
        chk_bit("R4", 3, 7, 1);
        chk_bit("R4", 3, 5, 0);
        // R5 receive-full bit remains after the condition leaves
        rx_count = 10; tick();
        chk_bit("R5", 3, 2, 1);
        chk_bit("R5", 4, 2, 0);
        // R6 event pulses
        rx_ovr_evt = 1; tick(); rx_ovr_evt = 0;
        chk_bit("R6", 3, 5, 1);
        timeout_evt = 1; tick(); timeout_evt = 0;
        chk_bit("R6", 3, 6, 1);
        // R8 write-one-to-clear on bits 2 and 5 only
        wr(3, 'h24);
        chk_bit("R8", 3, 2, 0);
        chk_bit("R8", 3, 5, 0);
        chk_bit("R8", 3, 6, 1);
        chk_rd("R8", 3);
        // R9 set wins over clear on receive empty
        rx_count = 0; tick();
        wr(3, 'h02);
        chk_bit("R9", 3, 1, 1);
        // R10 no mask, no interrupt
        checks++;
        if (irq !== 1'b0) begin errors++; $display("FAIL R10 irq actual=%0b expected=0", irq); end
        // R7 mask set and clear ports
        wr(0, 'h40); chk_val("R7", 2, 'h40);
        checks++;
        if (irq !== 1'b1) begin errors++; $display("FAIL R10 irq actual=%0b expected=1", irq); end
        wr(0, 'h01); chk_val("R7", 2, 'h41);
        wr(1, 'h40); chk_val("R7", 2, 'h01);
        wr(3, 'h01);
        checks++;
        if (irq !== 1'b0) begin errors++; $display("FAIL R10 irq actual=%0b expected=0", irq); end
        // R12 trigger level programming
        wr(5, 5); chk_val("R12", 5, 5);
        rx_count = 5; #1; chk_bit("R12", 4, 0, 1);
        rx_count = 4; #1; chk_bit("R12", 4, 0, 0);
        wr(6, 64); chk_val("R12", 6, 64);
        // Mixed traffic compared against the model
        for (int i = 0; i < 300; i++) begin
            rx_count    = CNT_W'((i * 7) % 65);
            tx_count    = CNT_W'((i * 13 + 3) % 65);
            rx_ovr_evt  = (i % 11 == 0);
            timeout_evt = (i % 17 == 0);
            wr_en   = (i % 3 == 0);
            wr_addr = 3'((i / 3) % 7);
            wr_data = DW'((i * 37) & 255);
            tick();
            case (i % 5)
                0: chk_rd("R7", 2);
                1: chk_rd("R5", 3);
                2: chk_rd("R2", 4);
                3: chk_rd("R12", 5);
                default: chk_rd("R12", 6);
            endcase
        end
        wr_en = 0; rx_ovr_evt = 0; timeout_evt = 0;
        // R11 reset mid-run
        rst_n = 0; tick(); tick();
        chk_val("R11", 3, 0);
        chk_val("R11", 5, 32);
        tick();
        finish_run();
    end
endmodule